// File: doc/BRIEF.md
# Self-Timed Successive-Approximation Conversion Controller

This block is the digital sequencer of a 12-bit differential charge-redistribution converter. A start pulse, taken from the system clock, begins each conversion. The block then runs a sampling phase and a short hold phase, and after that a chain of bit trials from the most significant bit down to the least significant bit. It has no fixed bit clock. Each trial ends when the dynamic comparator resolves. The block sees this because the comparator's two outputs, both high while the comparator is in reset, start to differ. The exclusive-OR of the pair, brought into the fast sampling clock domain, becomes a one-cycle bit-done strobe.

For every bit, the block drives bottom-plate controls for the positive and the negative capacitor arrays. A 4-bit bit-index counter is decoded into one-hot trial selects. A per-bit latch array captures each decision and holds that bit's switch setting while later trials run. When the last decision is in, the block presents the code with a one-cycle ready flag. A new start at any moment abandons the conversion in progress.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset, `samp_o`, `hold_o`, `cmp_trig_o` and `rdy_o` are low, and `code_o` and `pos_sw_o` are zero.
- R2: A start sampled on a clock edge drives `samp_o` high for exactly SAMP_CYC cycles (default 4), then `hold_o` for exactly HOLD_CYC cycles (default 2), and then raises `cmp_trig_o` for the first trial. `cmp_trig_o` is never high together with `samp_o` or `hold_o`.
- R3: During sampling and hold, every `pos_sw_o` bit is 0 and every `neg_sw_o` bit is 1. A 0 means the plate is on the negative reference and a 1 means it is on the positive reference; `samp_o` high additionally routes the upper-half plates to the input.
- R4: While bit k is under trial, `pos_sw_o` holds the decided upper bits, 1 in bit k, and 0 below it. At most one trial select is active, and `neg_sw_o` is always the bitwise complement of `pos_sw_o`.
- R5: A decision is taken on the rising edge of the exclusive-OR of `cmp_p_i` and `cmp_n_i`, after a two-stage synchronizer. The current bit becomes 1 when `cmp_p_i`=1 and `cmp_n_i`=0, and 0 when `cmp_p_i`=0 and `cmp_n_i`=1. Bits are decided from bit 11 down to bit 0.
- R6: After each decision, `cmp_trig_o` drops. It rises again only once the synchronized outputs of the comparator are equal again, so it stays low for at least two cycles.
- R7: After the twelfth decision, `rdy_o` is high for exactly one cycle and `code_o` carries the result with the MSB in bit 11. `code_o` holds that value until the next start.
- R8: A comparator strobe that arrives while no trial is running is ignored: `code_o` keeps its value and no `rdy_o` occurs.
- R9: A start during a conversion aborts it. On the next cycle `code_o` is zero and `samp_o` is high, and the aborted conversion never raises `rdy_o`.
- R10: The result is correct whatever the comparator's decision time is, and that time may differ from bit to bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle conversion start taken from the system clock |
| cmp_p_i | input | 1 | Comparator positive output (high in reset) |
| cmp_n_i | input | 1 | Comparator negative output (high in reset) |
| samp_o | output | 1 | Sampling phase: upper plates on input, array outputs at common mode |
| hold_o | output | 1 | Hold phase before the first trial |
| cmp_trig_o | output | 1 | Comparator enable: high evaluates, low resets |
| pos_sw_o | output | 12 | Positive-array plate control per bit, 1 = positive reference |
| neg_sw_o | output | 12 | Negative-array plate control per bit, 1 = positive reference |
| code_o | output | 12 | Conversion result, MSB in bit 11 |
| rdy_o | output | 1 | One-cycle result-valid pulse |

## Verification
The hardest cases to reach are a comparator strobe arriving while the controller is idle, and a restart landing in the middle of the trial chain. The bench uses an ideal comparator model that compares a chosen input code with the plate word. That model can be told to force its outputs apart while it is held in reset, which makes a spurious strobe in idle. The driver also issues a second start a fixed number of cycles into a conversion, so that the abort falls inside the bit trials. The model's decision delay depends on the trial word, which makes the pacing differ from one bit to the next.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SAMPLE = 3'd1,
    PH_HOLD   = 3'd2,
    PH_RUN    = 3'd3,
    PH_REARM  = 3'd4
  } phase_e;
endpackage

// File: rtl/sar_strobe_sync.sv
module sar_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_p,
  input  logic cmp_n,
  output logic diff_lvl,
  output logic done_pulse,
  output logic decision
);
  logic [STAGES-1:0] p_q;
  logic [STAGES-1:0] n_q;
  logic              diff_prev_q;

  // Synchronizer chain; reset value mirrors comparator reset (both high)
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          p_q[s] <= 1'b1;
          n_q[s] <= 1'b1;
        end else begin
          p_q[s] <= cmp_p;
          n_q[s] <= cmp_n;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          p_q[s] <= 1'b1;
          n_q[s] <= 1'b1;
        end else begin
          p_q[s] <= p_q[s-1];
          n_q[s] <= n_q[s-1];
        end
      end
    end
  end

  assign diff_lvl = p_q[STAGES-1] ^ n_q[STAGES-1];
  assign decision = p_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) diff_prev_q <= 1'b0;
    else        diff_prev_q <= diff_lvl;
  end

  assign done_pulse = diff_lvl & ~diff_prev_q;
endmodule

// File: rtl/sar_phase_fsm.sv
module sar_phase_fsm
  import sar_ctrl_pkg::*;
#(
  parameter int N_BITS   = 12,
  parameter int SAMP_CYC = 4,
  parameter int HOLD_CYC = 2,
  localparam int CNT_W   = $clog2(N_BITS),
  localparam int TMR_MAX = (SAMP_CYC > HOLD_CYC) ? SAMP_CYC : HOLD_CYC,
  localparam int TMR_W   = $clog2(TMR_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             bit_done,
  input  logic             diff_lvl,
  output phase_e           phase,
  output logic [CNT_W-1:0] bit_idx,
  output logic             capture,
  output logic             clear,
  output logic             rdy
);
  phase_e           phase_q, phase_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             rdy_q, rdy_d;

  always_comb begin
    phase_d = phase_q;
    tmr_d   = tmr_q;
    idx_d   = idx_q;
    rdy_d   = 1'b0;
    if (start) begin
      phase_d = PH_SAMPLE;
      tmr_d   = '0;
      idx_d   = '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: ;
        PH_SAMPLE: begin
          if (tmr_q == TMR_W'(SAMP_CYC - 1)) begin
            phase_d = PH_HOLD;
            tmr_d   = '0;
          end else begin
            tmr_d = tmr_q + 1'b1;
          end
        end
        PH_HOLD: begin
          if (tmr_q == TMR_W'(HOLD_CYC - 1)) begin
            phase_d = PH_RUN;
            tmr_d   = '0;
          end else begin
            tmr_d = tmr_q + 1'b1;
          end
        end
        PH_RUN: begin
          if (bit_done) begin
            if (idx_q == CNT_W'(N_BITS - 1)) begin
              phase_d = PH_IDLE;
              idx_d   = '0;
              rdy_d   = 1'b1;
            end else begin
              phase_d = PH_REARM;
              idx_d   = idx_q + 1'b1;
            end
          end
        end
        PH_REARM: begin
          if (!diff_lvl) phase_d = PH_RUN;
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      tmr_q   <= '0;
      idx_q   <= '0;
      rdy_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      tmr_q   <= tmr_d;
      idx_q   <= idx_d;
      rdy_q   <= rdy_d;
    end
  end

  assign phase   = phase_q;
  assign bit_idx = idx_q;
  assign capture = (phase_q == PH_RUN) && bit_done && !start;
  assign clear   = start;
  assign rdy     = rdy_q;
endmodule

// File: rtl/sar_bit_decoder.sv
module sar_bit_decoder #(
  parameter int N_BITS  = 12,
  localparam int CNT_W  = $clog2(N_BITS)
) (
  input  logic [CNT_W-1:0]  idx,
  input  logic              en,
  output logic [N_BITS-1:0] sel
);
  logic [CNT_W-1:0] idx_n;
  assign idx_n = ~idx;

  // Index 0 selects the MSB; true and complement forms both feed the match
  for (genvar g = 0; g < N_BITS; g++) begin : g_sel
    localparam logic [CNT_W-1:0] MATCH = CNT_W'(N_BITS - 1 - g);
    assign sel[g] = en && (idx == MATCH) && (idx_n == ~MATCH);
  end
endmodule

// File: rtl/sar_latch_array.sv
module sar_latch_array #(
  parameter int N_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic [N_BITS-1:0] sel,
  input  logic              decision,
  output logic [N_BITS-1:0] bits
);
  for (genvar g = 0; g < N_BITS; g++) begin : g_cell
    logic cell_q;
    logic cell_en;
    assign cell_en = clear || (capture && sel[g]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cell_q <= 1'b0;
      else if (cell_en) cell_q <= clear ? 1'b0 : decision;
    end
    assign bits[g] = cell_q;
  end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_ctrl_pkg::*;
#(
  parameter int N_BITS      = 12,
  parameter int SAMP_CYC    = 4,
  parameter int HOLD_CYC    = 2,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(N_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cmp_p_i,
  input  logic              cmp_n_i,
  output logic              samp_o,
  output logic              hold_o,
  output logic              cmp_trig_o,
  output logic [N_BITS-1:0] pos_sw_o,
  output logic [N_BITS-1:0] neg_sw_o,
  output logic [N_BITS-1:0] code_o,
  output logic              rdy_o
);
  phase_e            phase;
  logic [CNT_W-1:0]  bit_idx;
  logic              diff_lvl;
  logic              bit_done;
  logic              decision;
  logic              capture;
  logic              clear;
  logic              trial_en;
  logic [N_BITS-1:0] sel;
  logic [N_BITS-1:0] bits;

  sar_strobe_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_p      (cmp_p_i),
    .cmp_n      (cmp_n_i),
    .diff_lvl   (diff_lvl),
    .done_pulse (bit_done),
    .decision   (decision)
  );

  sar_phase_fsm #(
    .N_BITS   (N_BITS),
    .SAMP_CYC (SAMP_CYC),
    .HOLD_CYC (HOLD_CYC)
  ) fsm_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_i),
    .bit_done (bit_done),
    .diff_lvl (diff_lvl),
    .phase    (phase),
    .bit_idx  (bit_idx),
    .capture  (capture),
    .clear    (clear),
    .rdy      (rdy_o)
  );

  assign trial_en = (phase == PH_RUN) || (phase == PH_REARM);

  sar_bit_decoder #(.N_BITS(N_BITS)) dec_i (
    .idx (bit_idx),
    .en  (trial_en),
    .sel (sel)
  );

  sar_latch_array #(.N_BITS(N_BITS)) lat_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .capture  (capture),
    .sel      (sel),
    .decision (decision),
    .bits     (bits)
  );

  assign samp_o     = (phase == PH_SAMPLE);
  assign hold_o     = (phase == PH_HOLD);
  assign cmp_trig_o = (phase == PH_RUN);
  assign pos_sw_o   = bits | sel;
  assign neg_sw_o   = ~pos_sw_o;
  assign code_o     = bits;
endmodule

// File: rtl/sar_seq_ctrl_chk.sv
module sar_seq_ctrl_chk
  import sar_ctrl_pkg::*;
#(
  parameter int N_BITS = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              samp_o,
  input logic              hold_o,
  input logic              cmp_trig_o,
  input logic [N_BITS-1:0] code_o,
  input logic              rdy_o,
  input phase_e            phase,
  input logic [N_BITS-1:0] sel
);
  p_rdy_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |=> !rdy_o);

  p_abort_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (samp_o && !rdy_o && (code_o == '0)));

  p_trig_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_trig_o |-> !(samp_o || hold_o));

  p_hold_after_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(samp_o) |-> hold_o);

  p_idle_code_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !start_i) |=> $stable(code_o));

  p_sel_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
endmodule

bind sar_seq_ctrl sar_seq_ctrl_chk #(.N_BITS(N_BITS)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .samp_o     (samp_o),
  .hold_o     (hold_o),
  .cmp_trig_o (cmp_trig_o),
  .code_o     (code_o),
  .rdy_o      (rdy_o),
  .phase      (phase),
  .sel        (sel)
);

// File: tb/sar_seq_ctrl_tb_top.sv
module sar_seq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB   = 12;
  localparam int SAMP = 4;
  localparam int HOLD = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          cmp_p = 1'b1;
  logic          cmp_n = 1'b1;
  logic          samp_o, hold_o, cmp_trig_o, rdy_o;
  logic [NB-1:0] pos_sw_o, neg_sw_o, code_o;

  int  checks = 0;
  int  failures = 0;
  int  rdy_cnt = 0;
  int  vin = 0;
  int  dly = 1;
  int  ccnt = 0;
  bit  glitch = 1'b0;
  bit  done_flag = 1'b0;
  int  exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_seq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .cmp_p_i(cmp_p), .cmp_n_i(cmp_n),
    .samp_o(samp_o), .hold_o(hold_o), .cmp_trig_o(cmp_trig_o),
    .pos_sw_o(pos_sw_o), .neg_sw_o(neg_sw_o), .code_o(code_o), .rdy_o(rdy_o)
  );

  // Ideal comparator: delay depends on the trial word so pacing varies per bit
  always @(negedge clk) begin
    if (!cmp_trig_o) begin
      cmp_p <= 1'b1;
      cmp_n <= glitch ? 1'b0 : 1'b1;
      ccnt  <= 0;
    end else if (ccnt >= dly + (int'(pos_sw_o) % 3)) begin
      if (vin >= int'(pos_sw_o)) begin cmp_p <= 1'b1; cmp_n <= 1'b0; end
      else                       begin cmp_p <= 1'b0; cmp_n <= 1'b1; end
    end else begin
      ccnt <= ccnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rdy_o) begin
      rdy_cnt++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected ready", int'(code_o), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(code_o == NB'(e), "R7/R5/R10 code", int'(code_o), e);
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_rdy();
    int target;
    target = rdy_cnt + 1;
    while (rdy_cnt < target) @(negedge clk);
  endtask

  task automatic convert(input int val, input int d);
    vin = val; dly = d;
    exp_q.push_back(val);
    pulse_start();
    wait_rdy();
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    int saved;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!samp_o && !hold_o, "R1 phase outputs", {samp_o, hold_o}, 0);
    check(!cmp_trig_o, "R1 trig", cmp_trig_o, 0);
    check(!rdy_o, "R1 ready", rdy_o, 0);
    check(code_o == '0 && pos_sw_o == '0, "R1 code/switch", int'(code_o), 0);

    // Detailed conversion: phases, switch words, pacing
    vin = 12'hA5C; dly = 1;
    exp_q.push_back(12'hA5C);
    pulse_start();
    check(pos_sw_o == '0 && neg_sw_o == '1, "R3 sample switches", int'(pos_sw_o), 0);
    n = 0;
    while (samp_o) begin n++; @(negedge clk); end
    check(n == SAMP, "R2 sample length", n, SAMP);
    check(pos_sw_o == '0 && neg_sw_o == '1, "R3 hold switches", int'(neg_sw_o), 12'hFFF);
    n = 0;
    while (hold_o) begin n++; @(negedge clk); end
    check(n == HOLD, "R2 hold length", n, HOLD);
    check(cmp_trig_o == 1'b1, "R2 trial start", cmp_trig_o, 1);
    check(pos_sw_o == 12'h800 && neg_sw_o == 12'h7FF, "R4 first trial word", int'(pos_sw_o), 12'h800);
    while (cmp_trig_o) @(negedge clk);
    check(pos_sw_o == 12'hC00, "R4 second trial word", int'(pos_sw_o), 12'hC00);
    check(neg_sw_o == ~pos_sw_o, "R4 complement", int'(neg_sw_o), int'(~pos_sw_o));
    n = 0;
    while (!cmp_trig_o) begin n++; @(negedge clk); end
    check(n >= 2, "R6 rearm gap", n, 2);
    wait_rdy();
    @(negedge clk);
    check(!rdy_o, "R7 ready one cycle", rdy_o, 0);
    check(code_o == 12'hA5C, "R7 code held", int'(code_o), 12'hA5C);

    // Corner codes and comparator delays
    convert(0, 1);
    convert(12'hFFF, 3);
    convert(12'h800, 2);
    convert(12'h7FF, 5);
    convert(12'h555, 1);
    convert(12'h001, 7);

    // R8: strobe while idle is ignored
    saved = rdy_cnt;
    glitch = 1'b1;
    repeat (6) @(negedge clk);
    glitch = 1'b0;
    repeat (6) @(negedge clk);
    check(code_o == 12'h001, "R8 idle strobe code", int'(code_o), 12'h001);
    check(rdy_cnt == saved, "R8 idle strobe ready", rdy_cnt, saved);

    // R9: abort mid-trial, no partial ready
    vin = 12'h3C3; dly = 2;
    saved = rdy_cnt;
    pulse_start();
    repeat (30) @(negedge clk);
    check(rdy_cnt == saved, "R9 no ready before abort", rdy_cnt, saved);
    vin = 12'h9E1;
    exp_q.push_back(12'h9E1);
    pulse_start();
    check(code_o == '0 && samp_o, "R9 cleared on restart", int'(code_o), 0);
    wait_rdy();
    check(rdy_cnt == saved + 1, "R9 single ready", rdy_cnt, saved + 1);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule